// File: doc/BRIEF.md
# Fixed-Width Booth Multiplier with Error Compensation

This block multiplies two signed two's-complement operands of equal width and returns only the upper half of the product. The result is as wide as either operand. The multiplier operand is recoded into radix-4 Booth digits, and each digit selects one partial-product row built from the multiplicand. Only the product columns that belong to the result are summed. Every column below them is discarded.

In place of the discarded columns, the block adds a small number of compensation units at the least significant result column. That number is read from a table indexed by how many Booth digits are nonzero. The table rounds up half of that count by default. The result has a bounded error against the exactly truncated product, and the low half of the array is never built. An optional output register gives one cycle of latency. Without it the block is purely combinational.

Top module: `fw_booth_mult`

## Requirements
- R1: With OUT_REG=1, `prod` reads zero on every clock edge where `rst` is high.
- R2: With OUT_REG=1, `prod` shows the result for the operands present at the previous rising edge and does not change between edges. With OUT_REG=0, `prod` follows the operands without a clock.
- R3: When `mplier` is zero, `prod` is exactly zero for any `mcand`.
- R4: The operand `mplier` is split into D = ceil(WIDTH/2) digits. Digit i equals -2*m[2i+1] + m[2i] + m[2i-1], with m[-1]=0, and for odd WIDTH, m[WIDTH]=m[WIDTH-1]. Each digit carries a sign flag, a double flag and a nonzero flag, and neither the sign flag nor the double flag is set on a zero digit.
- R5: Digit i selects a row of WIDTH+1 bits at column 2i. The row holds the multiple |d|*mcand, bit-inverted when the digit is negative, and a +1 is due at column 2i for each negative digit. The row MSB, which sets the sign extension, equals nonzero AND (sign XOR mcand MSB).
- R6: `prod` equals, modulo 2^WIDTH, the sum over all rows of floor(rowvalue*4^i / 2^WIDTH) plus the compensation count of R8. Here rowvalue is d*mcand-1 for negative digits, d*mcand otherwise. All +1 bits and all row bits below column WIDTH are dropped, and nothing saturates.
- R7: The category index equals the number of nonzero digits, from 0 to D.
- R8: The compensation count is ceil(k/2) for category k when COMP_ROUND_UP=1, and floor(k/2) otherwise. Category 0 adds nothing.
- R9: For every operand pair, |prod - floor(mcand*mplier / 2^WIDTH)| is at most ceil(D/2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| mcand | input | WIDTH | Signed multiplicand |
| mplier | input | WIDTH | Signed multiplier, Booth-recoded |
| prod | output | WIDTH | Signed upper half of the product, compensated |

## Verification
The bench builds two instances of the block. The first has WIDTH=8 with the output register. It is driven with every one of the 65536 operand pairs, so the error bound and the exact compensation rule are checked over the whole input space, and the output's one-cycle latency can be observed. The second has WIDTH=11 without the register. Its odd width exercises the appended sign bit in the top digit and the combinational path, and it is driven with random operands plus both extreme values. Directed pairs cover the following cases:
- an all-zero multiplier;
- a zero multiplicand under negative digits, which gives a nonzero result;
- the full and empty categories.

// File: rtl/fw_booth_pkg.sv
`timescale 1ns/1ps
package fw_booth_pkg;

  typedef struct packed {
    logic neg;
    logic dbl;
    logic nz;
  } booth_digit_t;

  function automatic int digit_count(input int w);
    return (w + 1) / 2;
  endfunction

  function automatic int comp_carry(input int k, input bit round_up);
    return round_up ? (k + 1) / 2 : k / 2;
  endfunction

endpackage

// File: rtl/fwb_recoder.sv
`timescale 1ns/1ps
module fwb_recoder
  import fw_booth_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int DIGITS = 4
) (
  input  logic [WIDTH-1:0]          mplier,
  output booth_digit_t [DIGITS-1:0] digits
);
  localparam int EXT_W = 2 * DIGITS + 1;

  logic [EXT_W-1:0] ext;

  generate
    if (EXT_W == WIDTH + 2) begin : g_odd
      assign ext = {mplier[WIDTH-1], mplier, 1'b0};
    end else begin : g_even
      assign ext = {mplier, 1'b0};
    end
  endgenerate

  for (genvar gi = 0; gi < DIGITS; gi++) begin : g_dig
    logic [2:0]   grp;
    booth_digit_t d;
    assign grp = ext[2*gi+2 -: 3];
    always_comb begin
      d = '0;
      case (grp)
        3'b001, 3'b010: d.nz = 1'b1;
        3'b011:         begin d.nz = 1'b1; d.dbl = 1'b1; end
        3'b100:         begin d.nz = 1'b1; d.dbl = 1'b1; d.neg = 1'b1; end
        3'b101, 3'b110: begin d.nz = 1'b1; d.neg = 1'b1; end
        default:        d = '0;
      endcase
    end
    assign digits[gi] = d;
  end

endmodule

// File: rtl/fwb_rows.sv
`timescale 1ns/1ps
module fwb_rows
  import fw_booth_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int DIGITS = 4
) (
  input  logic [WIDTH-1:0]              mcand,
  input  booth_digit_t [DIGITS-1:0]     digits,
  output logic [DIGITS-1:0][WIDTH:0]    rows
);
  for (genvar gi = 0; gi < DIGITS; gi++) begin : g_row
    logic [WIDTH:0] mag;
    always_comb begin
      if (!digits[gi].nz)
        mag = '0;
      else if (digits[gi].dbl)
        mag = {mcand, 1'b0};
      else
        mag = {mcand[WIDTH-1], mcand};
    end
    assign rows[gi] = mag ^ {(WIDTH+1){digits[gi].neg}};
  end

endmodule

// File: rtl/fwb_category.sv
`timescale 1ns/1ps
module fwb_category #(
  parameter int DIGITS = 4,
  parameter int CAT_W  = 3
) (
  input  logic [DIGITS-1:0] nz,
  output logic [CAT_W-1:0]  cat
);
  always_comb begin
    cat = '0;
    for (int i = 0; i < DIGITS; i++)
      cat = cat + CAT_W'(nz[i]);
  end

endmodule

// File: rtl/fwb_carry_lut.sv
`timescale 1ns/1ps
module fwb_carry_lut
  import fw_booth_pkg::*;
#(
  parameter int DIGITS   = 4,
  parameter int CAT_W    = 3,
  parameter bit ROUND_UP = 1'b1
) (
  input  logic [CAT_W-1:0] cat,
  output logic [CAT_W-1:0] carry
);
  localparam int TBL_N = 2 ** CAT_W;

  logic [CAT_W-1:0] tbl [TBL_N];

  for (genvar k = 0; k < TBL_N; k++) begin : g_tbl
    localparam int VAL = (k <= DIGITS) ? comp_carry(k, ROUND_UP) : 0;
    assign tbl[k] = CAT_W'(VAL);
  end

  assign carry = tbl[cat];

endmodule

// File: rtl/fw_booth_mult.sv
`timescale 1ns/1ps
module fw_booth_mult
  import fw_booth_pkg::*;
#(
  parameter int WIDTH         = 8,
  parameter bit OUT_REG       = 1'b1,
  parameter bit COMP_ROUND_UP = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] mcand,
  input  logic [WIDTH-1:0] mplier,
  output logic [WIDTH-1:0] prod
);
  localparam int DIGITS = digit_count(WIDTH);
  localparam int CAT_W  = $clog2(DIGITS + 1);

  booth_digit_t [DIGITS-1:0]   digits;
  logic [DIGITS-1:0]           nz_v, neg_v, dbl_v;
  logic [DIGITS-1:0][WIDTH:0]  rows;
  logic [CAT_W-1:0]            cat, carry;
  logic [2*WIDTH-1:0]          shifted;
  logic [WIDTH-1:0]            sum;

  fwb_recoder #(.WIDTH(WIDTH), .DIGITS(DIGITS)) u_rec (
    .mplier (mplier),
    .digits (digits)
  );

  for (genvar gi = 0; gi < DIGITS; gi++) begin : g_flags
    assign nz_v[gi]  = digits[gi].nz;
    assign neg_v[gi] = digits[gi].neg;
    assign dbl_v[gi] = digits[gi].dbl;
  end

  fwb_rows #(.WIDTH(WIDTH), .DIGITS(DIGITS)) u_rows (
    .mcand  (mcand),
    .digits (digits),
    .rows   (rows)
  );

  fwb_category #(.DIGITS(DIGITS), .CAT_W(CAT_W)) u_cat (
    .nz  (nz_v),
    .cat (cat)
  );

  fwb_carry_lut #(.DIGITS(DIGITS), .CAT_W(CAT_W), .ROUND_UP(COMP_ROUND_UP)) u_lut (
    .cat   (cat),
    .carry (carry)
  );

  // Kept columns only: the upper half of each sign-extended, shifted row.
  always_comb begin
    sum     = WIDTH'(carry);
    shifted = '0;
    for (int i = 0; i < DIGITS; i++) begin
      shifted = {{(WIDTH-1){rows[i][WIDTH]}}, rows[i]} << (2 * i);
      sum     = sum + WIDTH'(shifted >> WIDTH);
    end
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) prod <= '0;
        else     prod <= sum;
      end
    end else begin : g_comb
      assign prod = sum;
    end
  endgenerate

  AST_DIGIT_FLAGS: assert property (@(posedge clk) disable iff (rst)
    ((dbl_v | neg_v) & ~nz_v) == '0); // R4

  for (genvar gi = 0; gi < DIGITS; gi++) begin : g_sx
    AST_SIGN_EXT: assert property (@(posedge clk) disable iff (rst)
      rows[gi][WIDTH] == (nz_v[gi] & (neg_v[gi] ^ mcand[WIDTH-1]))); // R5
  end

  AST_CATEGORY: assert property (@(posedge clk) disable iff (rst)
    int'(cat) == $countones(nz_v)); // R7

  AST_CARRY_HALF: assert property (@(posedge clk) disable iff (rst)
    (2 * int'(carry) <= int'(cat) + 1) && (2 * int'(carry) + 1 >= int'(cat))); // R8

  AST_ZERO_MULT: assert property (@(posedge clk) disable iff (rst)
    (mplier == '0) |-> (sum == '0)); // R3

endmodule

// File: tb/sim_fw_booth_mult.sv
`timescale 1ns/1ps
module sim_fw_booth_mult;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  a8  = '0, b8 = '0, p8;
  logic [10:0] a11 = '0, b11 = '0, p11;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  longint err_sum8 = 0;
  int  err_max8 = 0, err_max11 = 0;

  always #2.5 clk = ~clk;

  fw_booth_mult #(.WIDTH(8), .OUT_REG(1'b1)) u0 (
    .clk (clk), .rst (rst), .mcand (a8), .mplier (b8), .prod (p8)
  );

  fw_booth_mult #(.WIDTH(11), .OUT_REG(1'b0)) u1 (
    .clk (clk), .rst (rst), .mcand (a11), .mplier (b11), .prod (p11)
  );

  function automatic int wrap(input int v, input int n);
    return (v <<< (32 - n)) >>> (32 - n);
  endfunction

  function automatic int bitv(input int b, input int j);
    return (j < 0) ? 0 : ((b >>> j) & 1);
  endfunction

  // Expected output from R4, R5, R6, R8.
  function automatic int model(input int a, input int b, input int n);
    int dn = (n + 1) / 2;
    int acc = 0;
    int k = 0;
    for (int i = 0; i < dn; i++) begin
      int d = -2 * bitv(b, 2*i+1) + bitv(b, 2*i) + bitv(b, 2*i-1);
      int v = d * a - ((d < 0) ? 1 : 0);
      if (d != 0) k++;
      acc += (v <<< (2*i)) >>> n;
    end
    return wrap(acc + (k + 1) / 2, n);
  endfunction

  function automatic int exact_trunc(input int a, input int b, input int n);
    return (a * b) >>> n;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Registered instance: drive at a falling edge, check one edge later.
  task automatic run8(input int a, input int b, input string tag);
    int e = model(a, b, 8);
    a8 = 8'(a);
    b8 = 8'(b);
    @(negedge clk);
    chk(int'($signed(p8)) == e, tag, int'($signed(p8)), e);
  endtask

  task automatic run11(input int a, input int b, input string tag);
    int e = model(a, b, 11);
    a11 = 11'(a);
    b11 = 11'(b);
    #1;
    chk(int'($signed(p11)) == e, tag, int'($signed(p11)), e);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4321));
    a8 = 8'd100; b8 = 8'd77;
    repeat (3) @(negedge clk);
    chk(p8 == 8'd0, "R1", int'(p8), 0);                  // R1 reset value
    rst = 1'b0;

    // R2: register latency and hold between edges
    run8(3, 5, "R2");
    a8 = 8'(-7); b8 = 8'd9;
    #1;
    chk(int'($signed(p8)) == model(3, 5, 8), "R2", int'($signed(p8)), model(3, 5, 8));
    @(negedge clk);
    chk(int'($signed(p8)) == model(-7, 9, 8), "R2", int'($signed(p8)), model(-7, 9, 8));
    run11(-300, 77, "R2");

    // R3: zero multiplier
    run8(0, 0, "R3");
    run8(-128, 0, "R3");
    run8(127, 0, "R3");
    run11(-1024, 0, "R3");
    chk(p11 == 11'd0, "R3", int'(p11), 0);

    // R5: zero multiplicand under all-negative digits gives -2
    run8(0, -86, "R5");
    chk(int'($signed(p8)) == -2, "R5", int'($signed(p8)), -2);

    // R7, R8: all four digits +1 with a zero multiplicand gives 2
    run8(0, 85, "R8");
    chk(int'($signed(p8)) == 2, "R7", int'($signed(p8)), 2);
    run8(1, -128, "R7");

    // R6: operand extremes
    run8(-128, -128, "R6");
    run8(-128, 127, "R6");
    run8(127, -128, "R6");

    // R4: odd width, top digit relies on the appended sign bit
    run11(-1024, -1024, "R4");
    run11(1023, -1024, "R4");
    run11(-1024, 1023, "R4");
    run11(5, -683, "R4");

    // Exhaustive 8-bit sweep with random 11-bit operands alongside
    for (int a = -128; a < 128; a++) begin
      for (int b = -128; b < 128; b++) begin
        int ra = wrap(int'($urandom), 11);
        int rb = wrap(int'($urandom), 11);
        int e11, r11, o11, d11;
        int e8, r8, o8, d8;
        a8 = 8'(a); b8 = 8'(b);
        a11 = 11'(ra); b11 = 11'(rb);
        #1;
        e11 = model(ra, rb, 11);
        r11 = exact_trunc(ra, rb, 11);
        o11 = int'($signed(p11));
        d11 = (o11 > r11) ? o11 - r11 : r11 - o11;
        chk(o11 == e11, "R6", o11, e11);
        chk(d11 <= 3, "R9", o11, r11);
        if (d11 > err_max11) err_max11 = d11;
        @(negedge clk);
        e8 = model(a, b, 8);
        r8 = exact_trunc(a, b, 8);
        o8 = int'($signed(p8));
        d8 = (o8 > r8) ? o8 - r8 : r8 - o8;
        chk(o8 == e8, "R6", o8, e8);
        chk(d8 <= 2, "R9", o8, r8);
        err_sum8 += d8;
        if (d8 > err_max8) err_max8 = d8;
      end
    end

    $display("WIDTH=8 mean abs error %f LSB, max %0d LSB", real'(err_sum8) / 65536.0, err_max8);
    $display("WIDTH=11 max abs error %0d LSB", err_max11);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule